// File: doc/BRIEF.md
# Magic Packet Wake Controller

This block watches the byte stream of a network receiver for a wake-up frame. Such a frame carries a run of 0xFF sync bytes followed by the station's own 48-bit address repeated sixteen times, and the run may sit anywhere in the frame. When the block finds one, it sets three sticky status flags together. It then drives a gated interrupt request, a gated power-management event and an optional indicator LED. It also raises a suspend signal that keeps the host's receive and transmit descriptor polling halted.

The frame that carried the match is dropped rather than handed to the host. Polling stays halted until the system has shown two things: power-good has been seen high, and the mode enable has been seen low, in either order. Polling then carries on from where it stopped. After power-good has held the mode off, the mode re-arms only once power-good has stayed low for a minimum time, derived from the clock period. Re-arming by toggling the enable bit takes effect at once.

Top module: `mpkt_wake_ctrl`

## Requirements
- R1: A detection is a run of at least SYNC_BYTES (6) bytes of 0xFF immediately followed by ADDR_COPIES (16) back-to-back copies of `station_addr_i`, each copy sent most significant octet first (bits 47:40 first). The run may start at any byte of a frame. A byte that breaks the run restarts the sync search; if the breaking byte is 0xFF it counts as the first sync byte. Extra 0xFF bytes before the first address octet are accepted. A byte with `rx_sof_i` high starts a fresh search.
- R2: On the clock edge that samples the last address byte, `match_sts_o`, `mp_int_sts_o` and `pme_sts_o` all become 1 together, and they stay 1 until they are cleared.
- R3: `irq_o` is 1 one cycle after `mp_int_sts_o`, `irq_en_i` and `mp_irq_en_i` are all 1, and 0 otherwise.
- R4: `pme_o` is 1 one cycle after `pme_sts_o` is 1 while `pme_en_i` or `pme_ovr_i` is 1, and 0 otherwise.
- R5: `led_o` registers the indication `led_sel_i & match_sts_o`. When `led_pol_i`=1 the LED is active high; when `led_pol_i`=0 it is active low, so the output is the inverse of the indication.
- R6: `frame_drop_o` pulses for one cycle after the edge that samples the `rx_eof_i` byte of a frame in which a detection occurred; it stays 0 for any other frame.
- R7: A detection raises `rx_suspend_o`. It stays high until `pg_i` has been seen high and `mode_en_i` has been seen low, in either order. While it is high, no detection is made.
- R8: No detection is made while `pg_i` is 1, nor during the first PG_LOW_CYCLES = ceil(200 ns / CLK_PERIOD_NS) cycles after it falls. The search is held reset through that time, so a pattern that begins inside the window is ignored.
- R9: Clearing `mode_en_i` and setting it again re-arms detection at once, with no waiting time.
- R10: A 1 on `clr_match_i`, `clr_mp_int_i` or `clr_pme_i` clears the matching flag on the next edge and leaves the other two flags unchanged.
- R11: While `mode_en_i` is 0, no detection is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_byte_i | input | 8 | Receive byte |
| station_addr_i | input | 48 | Station address |
| mode_en_i | input | 1 | Wake mode enable |
| pg_i | input | 1 | Power-good |
| irq_en_i | input | 1 | Global interrupt enable |
| mp_irq_en_i | input | 1 | Wake interrupt enable |
| pme_en_i | input | 1 | Power event enable |
| pme_ovr_i | input | 1 | Power event enable override |
| led_sel_i | input | 1 | LED shows wake match |
| led_pol_i | input | 1 | LED active high when 1 |
| clr_match_i | input | 1 | Write-one-to-clear match flag |
| clr_mp_int_i | input | 1 | Write-one-to-clear interrupt flag |
| clr_pme_i | input | 1 | Write-one-to-clear power event flag |
| match_sts_o | output | 1 | Sticky match flag |
| mp_int_sts_o | output | 1 | Sticky wake interrupt flag |
| pme_sts_o | output | 1 | Sticky power event flag |
| irq_o | output | 1 | Interrupt request |
| pme_o | output | 1 | Power-management event |
| led_o | output | 1 | LED drive |
| rx_suspend_o | output | 1 | Halts descriptor polling |
| frame_drop_o | output | 1 | Discard the current frame |

## Verification
The search state is the part most likely to go wrong. If its octet or copy counter slips, a valid frame raises no flags and no drop pulse within two cycles of the eof byte, and a broken frame with 15 copies or 5 sync bytes shows flags it should not. A fault in the suspend sequencer shows up as `rx_suspend_o` falling after only one of the two resume events, or as flags set by a frame that arrives while polling is halted. A fault in the re-arm counter shows up as a match within the power-good window, or as a missing match just after it.

// File: rtl/mpkt_wake_pkg.sv
package mpkt_wake_pkg;
   typedef enum logic {SCAN_SYNC, SCAN_ADDR} scan_phase_t;
   typedef enum logic {SEQ_RUN, SEQ_HALT} seq_state_t;
   localparam int FLAG_MATCH = 0;
   localparam int FLAG_INT   = 1;
   localparam int FLAG_PME   = 2;
   localparam int NUM_FLAGS  = 3;
endpackage

// File: rtl/mpkt_pattern_scan.sv
module mpkt_pattern_scan
   import mpkt_wake_pkg::*;
#(
   parameter int ADDR_W      = 48,
   parameter int SYNC_BYTES  = 6,
   parameter int ADDR_COPIES = 16,
   parameter logic [7:0] SYNC_VAL = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_en_i,
   input  logic              valid_i,
   input  logic              sof_i,
   input  logic [7:0]        byte_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   localparam int OCTETS = ADDR_W / 8;
   localparam int OW     = $clog2(OCTETS);
   localparam int CW     = $clog2(ADDR_COPIES);
   localparam int SW     = $clog2(SYNC_BYTES + 1);
   localparam logic [OW-1:0] OCT_LAST  = OW'(OCTETS - 1);
   localparam logic [CW-1:0] COPY_LAST = CW'(ADDR_COPIES - 1);
   localparam logic [SW-1:0] SYNC_FULL = SW'(SYNC_BYTES);

   generate
      if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_addr
         $error("ADDR_W must be a multiple of 8 and at least 16");
      end
      if (SYNC_BYTES < 2) begin : g_bad_sync
         $error("SYNC_BYTES must be at least 2");
      end
      if (ADDR_COPIES < 2) begin : g_bad_copies
         $error("ADDR_COPIES must be at least 2");
      end
   endgenerate

   logic [7:0] octet [2**OW];
   generate
      for (genvar g = 0; g < 2**OW; g++) begin : g_octet
         if (g < OCTETS) begin : g_real
            assign octet[g] = addr_i[ADDR_W-1-8*g -: 8];
         end else begin : g_pad
            assign octet[g] = 8'h00;
         end
      end
   endgenerate

   scan_phase_t    phase_q, phase_n, ph;
   logic [SW-1:0]  sync_q, sync_n, sc;
   logic [OW-1:0]  oct_q, oct_n, oc;
   logic [CW-1:0]  copy_q, copy_n, cc;
   logic           hit;

   always_comb begin
      ph = phase_q;
      sc = sync_q;
      oc = oct_q;
      cc = copy_q;
      if (sof_i) begin
         ph = SCAN_SYNC;
         sc = '0;
         oc = '0;
         cc = '0;
      end
      phase_n = phase_q;
      sync_n  = sync_q;
      oct_n   = oct_q;
      copy_n  = copy_q;
      hit     = 1'b0;
      if (!scan_en_i) begin
         phase_n = SCAN_SYNC;
         sync_n  = '0;
         oct_n   = '0;
         copy_n  = '0;
      end else if (valid_i) begin
         phase_n = ph;
         sync_n  = sc;
         oct_n   = oc;
         copy_n  = cc;
         case (ph)
            SCAN_SYNC: begin
               if (byte_i == SYNC_VAL) begin
                  if (sc + 1'b1 == SYNC_FULL) begin
                     phase_n = SCAN_ADDR;
                     sync_n  = '0;
                     oct_n   = '0;
                     copy_n  = '0;
                  end else begin
                     sync_n = sc + 1'b1;
                  end
               end else begin
                  sync_n = '0;
               end
            end
            default: begin
               if (byte_i == octet[oc]) begin
                  if (oc == OCT_LAST) begin
                     oct_n = '0;
                     if (cc == COPY_LAST) begin
                        hit     = 1'b1;
                        phase_n = SCAN_SYNC;
                        copy_n  = '0;
                     end else begin
                        copy_n = cc + 1'b1;
                     end
                  end else begin
                     oct_n = oc + 1'b1;
                  end
               end else if (byte_i == SYNC_VAL && oc == '0 && cc == '0) begin
                  phase_n = SCAN_ADDR;
               end else begin
                  phase_n = SCAN_SYNC;
                  oct_n   = '0;
                  copy_n  = '0;
                  sync_n  = (byte_i == SYNC_VAL) ? SW'(1) : '0;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= SCAN_SYNC;
         sync_q  <= '0;
         oct_q   <= '0;
         copy_q  <= '0;
      end else begin
         phase_q <= phase_n;
         sync_q  <= sync_n;
         oct_q   <= oct_n;
         copy_q  <= copy_n;
      end
   end

   assign hit_o = hit;
endmodule

// File: rtl/mpkt_rearm_timer.sv
module mpkt_rearm_timer #(
   parameter int CLK_PERIOD_NS = 4,
   parameter int MIN_LOW_NS    = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pg_i,
   output logic low_ok_o
);
   localparam int LOW_CYCLES = (MIN_LOW_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
   localparam int TW         = $clog2(LOW_CYCLES + 1);
   localparam logic [TW-1:0] CNT_FULL = TW'(LOW_CYCLES);

   generate
      if (CLK_PERIOD_NS < 1 || MIN_LOW_NS < 1) begin : g_bad_time
         $error("timing parameters must be positive");
      end
   endgenerate

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= CNT_FULL;
      else if (pg_i)              cnt_q <= '0;
      else if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
   end

   assign low_ok_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/mpkt_wake_seq.sv
module mpkt_wake_seq
   import mpkt_wake_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mode_en_i,
   input  logic pg_i,
   input  logic pg_low_ok_i,
   input  logic hit_i,
   output logic scan_en_o,
   output logic suspend_o
);
   seq_state_t st_q;
   logic pg_seen_q, off_seen_q;
   logic pg_seen, off_seen;

   assign pg_seen  = pg_seen_q | pg_i;
   assign off_seen = off_seen_q | ~mode_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SEQ_RUN;
         pg_seen_q  <= 1'b0;
         off_seen_q <= 1'b0;
      end else begin
         case (st_q)
            SEQ_RUN: begin
               pg_seen_q  <= 1'b0;
               off_seen_q <= 1'b0;
               if (hit_i) st_q <= SEQ_HALT;
            end
            default: begin
               if (pg_seen && off_seen) begin
                  st_q       <= SEQ_RUN;
                  pg_seen_q  <= 1'b0;
                  off_seen_q <= 1'b0;
               end else begin
                  pg_seen_q  <= pg_seen;
                  off_seen_q <= off_seen;
               end
            end
         endcase
      end
   end

   assign suspend_o = (st_q == SEQ_HALT);
   assign scan_en_o = mode_en_i & ~pg_i & pg_low_ok_i & (st_q == SEQ_RUN);
endmodule

// File: rtl/mpkt_sticky_flag.sv
module mpkt_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/mpkt_wake_ctrl.sv
module mpkt_wake_ctrl
   import mpkt_wake_pkg::*;
#(
   parameter int ADDR_W        = 48,
   parameter int SYNC_BYTES    = 6,
   parameter int ADDR_COPIES   = 16,
   parameter int CLK_PERIOD_NS = 4,
   parameter int MIN_LOW_NS    = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid_i,
   input  logic              rx_sof_i,
   input  logic              rx_eof_i,
   input  logic [7:0]        rx_byte_i,
   input  logic [ADDR_W-1:0] station_addr_i,
   input  logic              mode_en_i,
   input  logic              pg_i,
   input  logic              irq_en_i,
   input  logic              mp_irq_en_i,
   input  logic              pme_en_i,
   input  logic              pme_ovr_i,
   input  logic              led_sel_i,
   input  logic              led_pol_i,
   input  logic              clr_match_i,
   input  logic              clr_mp_int_i,
   input  logic              clr_pme_i,
   output logic              match_sts_o,
   output logic              mp_int_sts_o,
   output logic              pme_sts_o,
   output logic              irq_o,
   output logic              pme_o,
   output logic              led_o,
   output logic              rx_suspend_o,
   output logic              frame_drop_o
);
   logic hit, scan_en, pg_low_ok;
   logic [NUM_FLAGS-1:0] flag_clr, flag_q;
   logic frame_hit_q, drop_q, irq_q, pme_q, led_q;

   mpkt_rearm_timer #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .MIN_LOW_NS(MIN_LOW_NS)) u_timer (
      .clk(clk), .rst_n(rst_n), .pg_i(pg_i), .low_ok_o(pg_low_ok)
   );

   mpkt_wake_seq u_seq (
      .clk(clk), .rst_n(rst_n), .mode_en_i(mode_en_i), .pg_i(pg_i),
      .pg_low_ok_i(pg_low_ok), .hit_i(hit), .scan_en_o(scan_en),
      .suspend_o(rx_suspend_o)
   );

   mpkt_pattern_scan #(.ADDR_W(ADDR_W), .SYNC_BYTES(SYNC_BYTES),
                       .ADDR_COPIES(ADDR_COPIES)) u_scan (
      .clk(clk), .rst_n(rst_n), .scan_en_i(scan_en), .valid_i(rx_valid_i),
      .sof_i(rx_sof_i), .byte_i(rx_byte_i), .addr_i(station_addr_i), .hit_o(hit)
   );

   assign flag_clr[FLAG_MATCH] = clr_match_i;
   assign flag_clr[FLAG_INT]   = clr_mp_int_i;
   assign flag_clr[FLAG_PME]   = clr_pme_i;

   generate
      for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
         mpkt_sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(hit), .clr_i(flag_clr[f]),
            .flag_o(flag_q[f])
         );
      end
   endgenerate

   assign match_sts_o  = flag_q[FLAG_MATCH];
   assign mp_int_sts_o = flag_q[FLAG_INT];
   assign pme_sts_o    = flag_q[FLAG_PME];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_hit_q <= 1'b0;
         drop_q      <= 1'b0;
      end else begin
         drop_q <= rx_valid_i & rx_eof_i & (hit | (frame_hit_q & ~rx_sof_i));
         if (rx_valid_i & (rx_sof_i | rx_eof_i)) frame_hit_q <= hit & ~rx_eof_i;
         else if (hit)                          frame_hit_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         pme_q <= 1'b0;
         led_q <= 1'b0;
      end else begin
         irq_q <= flag_q[FLAG_INT] & irq_en_i & mp_irq_en_i;
         pme_q <= flag_q[FLAG_PME] & (pme_en_i | pme_ovr_i);
         led_q <= led_pol_i ? (led_sel_i & flag_q[FLAG_MATCH])
                            : ~(led_sel_i & flag_q[FLAG_MATCH]);
      end
   end

   assign frame_drop_o = drop_q;
   assign irq_o        = irq_q;
   assign pme_o        = pme_q;
   assign led_o        = led_q;
endmodule

// File: rtl/mpkt_wake_chk.sv
module mpkt_wake_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_valid_i,
   input logic rx_eof_i,
   input logic mode_en_i,
   input logic pg_i,
   input logic irq_en_i,
   input logic mp_irq_en_i,
   input logic pme_en_i,
   input logic pme_ovr_i,
   input logic clr_match_i,
   input logic match_sts_o,
   input logic mp_int_sts_o,
   input logic pme_sts_o,
   input logic irq_o,
   input logic pme_o,
   input logic rx_suspend_o,
   input logic frame_drop_o,
   input logic hit,
   input logic pg_low_ok
);
   AST_FLAGS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_sts_o) |-> (mp_int_sts_o && pme_sts_o)); // R2
   AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(irq_en_i && mp_irq_en_i)); // R3
   AST_PME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      pme_o |-> $past(pme_en_i || pme_ovr_i)); // R4
   AST_DROP_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop_o |-> $past(rx_valid_i && rx_eof_i)); // R6
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_suspend_o && !pg_i && mode_en_i) |=> rx_suspend_o); // R7
   AST_NO_HIT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !rx_suspend_o); // R7
   AST_PG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pg_i) |-> !pg_low_ok); // R8
   AST_W1C_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_match_i && !hit) |=> !match_sts_o); // R10
   AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> mode_en_i); // R11
endmodule

bind mpkt_wake_ctrl mpkt_wake_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid_i), .rx_eof_i(rx_eof_i),
   .mode_en_i(mode_en_i), .pg_i(pg_i), .irq_en_i(irq_en_i),
   .mp_irq_en_i(mp_irq_en_i), .pme_en_i(pme_en_i), .pme_ovr_i(pme_ovr_i),
   .clr_match_i(clr_match_i), .match_sts_o(match_sts_o),
   .mp_int_sts_o(mp_int_sts_o), .pme_sts_o(pme_sts_o), .irq_o(irq_o),
   .pme_o(pme_o), .rx_suspend_o(rx_suspend_o), .frame_drop_o(frame_drop_o),
   .hit(hit), .pg_low_ok(pg_low_ok)
);

// File: tb/mpkt_wake_ctrl_bench.sv
module mpkt_wake_ctrl_bench;
   localparam logic [47:0] STA = 48'h021A3C4D5E6F;
   localparam int WAIT_OK = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
   logic [7:0] rx_byte = 8'h00;
   logic mode_en = 0, pg = 0, irq_en = 0, mp_irq_en = 0, pme_en = 0, pme_ovr = 0;
   logic led_sel = 0, led_pol = 0, clr_match = 0, clr_int = 0, clr_pme = 0;
   logic match_sts, int_sts, pme_sts, irq, pme, led, suspend, drop;
   int nvec = 0, nfail = 0;

   always #2 clk = ~clk;

   mpkt_wake_ctrl u_mpkt_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
      .rx_eof_i(rx_eof), .rx_byte_i(rx_byte), .station_addr_i(STA),
      .mode_en_i(mode_en), .pg_i(pg), .irq_en_i(irq_en), .mp_irq_en_i(mp_irq_en),
      .pme_en_i(pme_en), .pme_ovr_i(pme_ovr), .led_sel_i(led_sel), .led_pol_i(led_pol),
      .clr_match_i(clr_match), .clr_mp_int_i(clr_int), .clr_pme_i(clr_pme),
      .match_sts_o(match_sts), .mp_int_sts_o(int_sts), .pme_sts_o(pme_sts),
      .irq_o(irq), .pme_o(pme), .led_o(led), .rx_suspend_o(suspend),
      .frame_drop_o(drop)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic put(input logic [7:0] b, input logic s, input logic e);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b; rx_sof = s; rx_eof = e;
   endtask

   // R1 stimulus: filler, sync run, address copies, breaker, trailer with eof
   task automatic send_frame(input int pre, input int ffs, input int copies,
                             input logic exp_hit);
      put(8'h55, 1'b1, 1'b0);
      for (int i = 1; i < pre; i++) put(8'h55, 1'b0, 1'b0);
      for (int i = 0; i < ffs; i++) put(8'hFF, 1'b0, 1'b0);
      for (int c = 0; c < copies; c++)
         for (int o = 0; o < 6; o++) put(STA[47-8*o -: 8], 1'b0, 1'b0);
      put(8'h00, 1'b0, 1'b0);
      put(8'hA5, 1'b0, 1'b1);
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      chk("R6 drop pulse", {7'd0, drop}, {7'd0, exp_hit});
      @(negedge clk);
      chk("R6 drop single cycle", {7'd0, drop}, 8'd0);
   endtask

   task automatic chk_flags(input string tag, input logic exp);
      chk(tag, {5'd0, match_sts, int_sts, pme_sts}, exp ? 8'd7 : 8'd0);
   endtask

   task automatic clear_all();
      @(negedge clk); clr_match = 1; clr_int = 1; clr_pme = 1;
      @(negedge clk); clr_match = 0; clr_int = 0; clr_pme = 0;
   endtask

   task automatic resume_and_arm();
      pg = 1; mode_en = 0; wait_cyc(2);
      pg = 0; mode_en = 1; clear_all(); wait_cyc(WAIT_OK);
   endtask

   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      chk_flags("R2 reset flags", 1'b0);
      chk("R7 reset suspend", {7'd0, suspend}, 8'd0);
      chk("R3 reset irq", {7'd0, irq}, 8'd0);
      chk("R4 reset pme", {7'd0, pme}, 8'd0);
      chk("R5 reset led low-active idle", {7'd0, led}, 8'd1);

      // R11: mode off
      send_frame(2, 6, 16, 1'b0);
      chk_flags("R11 disabled no flags", 1'b0);

      mode_en = 1;
      // R1: broken patterns
      send_frame(2, 6, 15, 1'b0);
      chk_flags("R1 fifteen copies", 1'b0);
      send_frame(2, 5, 16, 1'b0);
      chk_flags("R1 five sync bytes", 1'b0);

      // R1/R2/R7: valid, extra sync bytes, mid-frame
      send_frame(7, 9, 16, 1'b1);
      chk_flags("R2 flags set together", 1'b1);
      chk("R7 suspend raised", {7'd0, suspend}, 8'd1);

      // R3/R4/R5 gating sweep
      for (int m = 0; m < 16; m++) begin
         for (int k = 0; k < 4; k++) begin
            irq_en = m[0]; mp_irq_en = m[1]; pme_en = m[2]; pme_ovr = m[3];
            led_sel = k[0]; led_pol = k[1];
            wait_cyc(2);
            chk("R3 irq gating", {7'd0, irq}, {7'd0, m[0] & m[1]});
            chk("R4 pme gating", {7'd0, pme}, {7'd0, m[2] | m[3]});
            chk("R5 led polarity", {7'd0, led}, {7'd0, k[1] ? k[0] : ~k[0]});
         end
      end

      // R10: individual clears
      irq_en = 1; mp_irq_en = 1; pme_en = 1; led_sel = 1; led_pol = 1;
      @(negedge clk); clr_match = 1; @(negedge clk); clr_match = 0;
      chk("R10 clear match only", {5'd0, match_sts, int_sts, pme_sts}, 8'd3);
      wait_cyc(1);
      chk("R5 led follows cleared match", {7'd0, led}, 8'd0);
      @(negedge clk); clr_int = 1; @(negedge clk); clr_int = 0;
      chk("R10 clear int only", {5'd0, match_sts, int_sts, pme_sts}, 8'd1);
      wait_cyc(1);
      chk("R3 irq drops with flag", {7'd0, irq}, 8'd0);
      @(negedge clk); clr_pme = 1; @(negedge clk); clr_pme = 0;
      chk("R10 clear pme", {5'd0, match_sts, int_sts, pme_sts}, 8'd0);

      // R7: halted, no detection
      send_frame(2, 6, 16, 1'b0);
      chk_flags("R7 no detection while halted", 1'b0);
      // R7: power-good first, then enable cleared
      pg = 1; wait_cyc(2); pg = 0; wait_cyc(2);
      chk("R7 held after pg only", {7'd0, suspend}, 8'd1);
      mode_en = 0; wait_cyc(2);
      chk("R7 resume after both", {7'd0, suspend}, 8'd0);

      mode_en = 1; wait_cyc(WAIT_OK);
      send_frame(3, 6, 16, 1'b1);
      chk_flags("R7 detects after resume", 1'b1);
      // R7: enable cleared first, then power-good
      mode_en = 0; wait_cyc(2);
      chk("R7 held after enable off only", {7'd0, suspend}, 8'd1);
      mode_en = 1; wait_cyc(2);
      chk("R7 still held", {7'd0, suspend}, 8'd1);
      pg = 1; wait_cyc(2);
      chk("R7 resume other order", {7'd0, suspend}, 8'd0);
      clear_all();

      // R8: pg high, then pattern right after pg falls
      send_frame(2, 6, 16, 1'b0);
      chk_flags("R8 ignored while pg high", 1'b0);
      pg = 0;
      send_frame(2, 6, 16, 1'b0);
      chk_flags("R8 ignored inside low window", 1'b0);
      wait_cyc(WAIT_OK);
      send_frame(2, 6, 16, 1'b1);
      chk_flags("R8 detects after window", 1'b1);

      // R9: enable toggle re-arms at once
      resume_and_arm();
      mode_en = 0; wait_cyc(1); mode_en = 1;
      send_frame(1, 6, 16, 1'b1);
      chk_flags("R9 immediate re-arm", 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule